// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Add Unit

This block computes C + A×B or C − A×B in a two-stage pipeline. The two multiplicands are W bits wide and the addend and result are 2W bits wide. The default W is 64, so the result is 128 bits. One control bit chooses whether both multiplicands are two's-complement or unsigned. A second control bit chooses addition or subtraction of the product. With the result the unit returns a flag that says whether the 2W-bit result fails to fit into W bits of the chosen signedness.

The product is formed from one partial-product row per multiplier bit. Each row is the multiplicand, extended to 2W bits, and shifted. In signed mode the multiplicand is sign-extended. In signed mode the row for the multiplier's top bit carries a negative weight, so that row is subtracted. In unsigned mode the multiplicand is zero-extended and every row is added. The unit accepts a new operation on every cycle. It has no stall or busy output, so a downstream stage can always take the result at a known cycle.

Top module: `mac_unit`

## Requirements
- R1: When `is_signed` is 1, `op_a` and `op_b` are read as two's-complement values. When it is 0, both are read as unsigned values.
- R2: When `subtract` is 0, `result` equals (`addend` + A×B) mod 2^(2W). When `subtract` is 1, `result` equals (`addend` − A×B) mod 2^(2W).
- R3: In signed mode a negative multiplicand or a negative multiplier gives the correctly signed product, including the case where both operands are the most negative value.
- R4: `ovf_out` is 1 exactly when the result does not fit into W bits of the chosen signedness. In signed mode this means the top W+1 result bits are not all equal. In unsigned mode this means the top W result bits are not all zero.
- R5: `valid_out` is high exactly two clock cycles after `valid_in` was high. A new operation can be accepted on every cycle. Each result and flag belongs to the operation issued two cycles earlier.
- R6: A synchronous reset clears every valid bit in the pipeline, so `valid_out` is 0 on the cycle after reset.
- R7: `ovf_out` is 0 on every cycle in which `valid_out` is 0.
- R8: A valid result of zero never raises `ovf_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Marks the operands on this cycle as an operation |
| is_signed | input | 1 | 1: the multiplicands are two's-complement; 0: they are unsigned |
| subtract | input | 1 | 1: addend − A×B; 0: addend + A×B |
| op_a | input | W | Multiplicand A |
| op_b | input | W | Multiplicand B |
| addend | input | 2W | Addend C |
| valid_out | output | 1 | High when `result` and `ovf_out` hold a completed operation |
| result | output | 2W | Multiply-add result |
| ovf_out | output | 1 | Result does not fit into W bits of the chosen signedness |

## Verification
The bench builds the unit with W = 4, which gives 8-bit results. At that width every pair of multiplicands can be tried in both signedness modes and both add and subtract modes, against addends chosen near the wrap and overflow boundaries. This covers the most-negative operand, the all-ones unsigned operands and the signed-overflow edges. Bubbles are placed in the issue stream, and each output is compared with a model that uses plain integer arithmetic, so both the latency and the back-to-back throughput are checked.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned MAC_LATENCY = 2;

  typedef enum logic {
    ACC_ADD = 1'b0,
    ACC_SUB = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/mac_pprows.sv
module mac_pprows #(
  parameter int W = 64
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  input  logic           signed_mode,
  output logic [2*W-1:0] product
);
  localparam int PW = 2 * W;

  // The multiplicand is sign-extended or zero-extended to the full product width.
  function automatic logic [PW-1:0] widen(input logic [W-1:0] v, input logic sgn);
    widen = {{(PW - W){sgn & v[W-1]}}, v};
  endfunction

  logic [PW-1:0] a_wide;
  logic [PW-1:0] rows [W+1];

  assign a_wide = widen(mcand, signed_mode);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_row
      assign rows[gi] = mplier[gi] ? (a_wide << gi) : '0;
    end
  endgenerate

  // The multiplier's sign bit is counted once with weight +2^(W-1) by the rows above.
  // This extra row removes a*2^W, so the net weight of that bit is -2^(W-1).
  assign rows[W] = (signed_mode & mplier[W-1]) ? (~(a_wide << W) + 1'b1) : '0;

  always_comb begin
    product = '0;
    for (int i = 0; i <= W; i++) product = product + rows[i];
  end
endmodule

// File: rtl/mac_ovf.sv
module mac_ovf #(
  parameter int W = 64
) (
  input  logic [2*W-1:0] value,
  input  logic           signed_mode,
  output logic           too_wide
);
  localparam int PW = 2 * W;

  logic [PW-W:0] hi_s;
  logic [PW-W-1:0] hi_u;
  logic fits_s;
  logic fits_u;

  assign hi_s   = value[PW-1:W-1];
  assign hi_u   = value[PW-1:W];
  assign fits_s = (&hi_s) | ~(|hi_s);
  assign fits_u = ~(|hi_u);
  assign too_wide = signed_mode ? ~fits_s : ~fits_u;
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic             is_signed,
  input  logic             subtract,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [2*W-1:0]   addend,
  output logic             valid_out,
  output logic [2*W-1:0]   result,
  output logic             ovf_out
);
  localparam int PW = 2 * W;

  // Stage 1: form the product.
  logic [PW-1:0] prod_c;
  logic          s1_valid;
  logic          s1_signed;
  acc_mode_e     s1_mode;
  logic [PW-1:0] s1_prod;
  logic [PW-1:0] s1_addend;

  mac_pprows #(.W(W)) u_rows (
    .mcand       (op_a),
    .mplier      (op_b),
    .signed_mode (is_signed),
    .product     (prod_c)
  );

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= valid_in;
    s1_signed <= is_signed;
    s1_mode   <= acc_mode_e'(subtract);
    s1_prod   <= prod_c;
    s1_addend <= addend;
  end

  // Stage 2: accumulate the product and test the overflow condition.
  logic [PW-1:0] acc_c;
  logic          wide_c;

  assign acc_c = (s1_mode == ACC_SUB) ? (s1_addend - s1_prod) : (s1_addend + s1_prod);

  mac_ovf #(.W(W)) u_ovf (
    .value       (acc_c),
    .signed_mode (s1_signed),
    .too_wide    (wide_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      ovf_out   <= 1'b0;
    end else begin
      valid_out <= s1_valid;
      ovf_out   <= s1_valid & wide_c;
    end
    result <= acc_c;
  end

  // Counts clock edges since reset, saturating at the pipeline depth.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'(MAC_LATENCY)) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'(MAC_LATENCY)) |-> (valid_out == $past(valid_in, 2)));

  assert_reset_clears_R6: assert property (@(posedge clk)
    $past(rst) |-> !valid_out);

  assert_ovf_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !valid_out |-> !ovf_out);

  assert_zero_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_out && result == '0) |-> !ovf_out);

  assert_zero_product_R2: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_prod == '0) |=> (result == $past(s1_addend)));
endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb_top;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_in = 1'b0;
  logic is_signed = 1'b0;
  logic subtract = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [PW-1:0] addend = '0;
  logic valid_out;
  logic [PW-1:0] result;
  logic ovf_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Two-entry model of the pipeline: index 1 is the operation due at the outputs now.
  bit        ev [2] = '{default: 1'b0};
  int        eres [2] = '{default: 0};
  bit        eovf [2] = '{default: 1'b0};

  always #10 clk = ~clk;

  mac_unit #(.W(W)) dut_i (
    .clk, .rst, .valid_in, .is_signed, .subtract,
    .op_a, .op_b, .addend, .valid_out, .result, .ovf_out
  );

  function automatic int to_int(input logic [W-1:0] v, input bit sgn);
    int x = int'(v);
    if (sgn && v[W-1]) x = x - (1 << W);
    return x;
  endfunction

  task automatic sample_outputs();
    n_tests++;
    if (valid_out !== ev[1]) begin
      n_fail++;
      $display("FAIL R5 valid_out: got %0b expected %0b", valid_out, ev[1]);
    end
    if (ev[1]) begin
      n_tests++;
      if (int'(result) != eres[1]) begin
        n_fail++;
        $display("FAIL R1 R2 R3 result: got %0d expected %0d", result, eres[1]);
      end
      n_tests++;
      if (ovf_out !== eovf[1]) begin
        n_fail++;
        $display("FAIL R4 R8 ovf_out: got %0b expected %0b (result %0d)", ovf_out, eovf[1], eres[1]);
      end
    end else begin
      n_tests++;
      if (ovf_out !== 1'b0) begin
        n_fail++;
        $display("FAIL R7 ovf_out while idle: got %0b expected 0", ovf_out);
      end
    end
  endtask

  task automatic step(input bit v, input bit sg, input bit sb,
                      input int a, input int b, input int c);
    int av;
    int bv;
    int r;
    int rs;
    bit ov;
    @(negedge clk);
    sample_outputs();
    av = to_int(W'(a), sg);
    bv = to_int(W'(b), sg);
    r  = sb ? (c - av * bv) : (c + av * bv);
    r  = r & ((1 << PW) - 1);
    rs = (r >= (1 << (PW - 1))) ? r - (1 << PW) : r;
    if (sg) ov = (rs < -(1 << (W - 1))) || (rs > (1 << (W - 1)) - 1);
    else    ov = (r > (1 << W) - 1);
    ev[1] = ev[0]; eres[1] = eres[0]; eovf[1] = eovf[0];
    ev[0] = v; eres[0] = r; eovf[0] = ov;
    valid_in  = v;
    is_signed = sg;
    subtract  = sb;
    op_a      = W'(a);
    op_b      = W'(b);
    addend    = PW'(c);
  endtask

  initial begin
    int cvals [6] = '{0, 5, 8'h7F, 8'h80, 8'hFF, 8'h37};
    int k = 0;
    repeat (3) @(negedge clk);
    // R6: outputs are idle while reset is held
    n_tests++;
    if (valid_out !== 1'b0 || ovf_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R6 reset state: valid_out %0b ovf_out %0b expected 0 0", valid_out, ovf_out);
    end
    rst = 1'b0;
    for (int sg = 0; sg < 2; sg++)
      for (int sb = 0; sb < 2; sb++)
        for (int ci = 0; ci < 6; ci++)
          for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++) begin
              k++;
              if (k % 13 == 4) step(1'b0, 1'b0, 1'b0, 0, 0, 0);
              step(1'b1, sg[0], sb[0], a, b, cvals[ci]);
            end
    // R6: a reset issued mid-stream drops the operations still in flight
    step(1'b1, 1'b1, 1'b0, 7, 7, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    n_tests++;
    if (valid_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R6 valid after reset: got %0b expected 0", valid_out);
    end
    ev = '{default: 1'b0};
    valid_in = 1'b0;
    repeat (3) step(1'b0, 1'b0, 1'b0, 0, 0, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule